// File: doc/BRIEF.md
# Free-running compare timer

The block is a system timer with a 64-bit count that only ever moves forward, plus one compare channel that raises an interrupt once the count has reached a programmed target. A divide-by-three prescaler on the input clock drives the count, so the count moves forward by one on every third clock.

Software reaches the block through a plain 32-bit register port. One bank holds the two halves of the count. These halves are read one at a time and are not latched together. The other bank holds a 52-bit target, made of a 32-bit low word and a 20-bit high word, and a control word. The control word carries an enable, an interrupt gate and a read-only hit flag. The only way to acknowledge the interrupt is to clear the enable, which also clears the hit flag. A read is accepted in the cycle `bus_rd` is high. Its data appears in the next cycle together with `bus_rvalid`. Writes take effect at the clock edge that samples them. The port never stalls, so it has no back-pressure.

Top module: `cmpt_timer`

## Requirements
- R1: After reset the count is zero. It moves forward by exactly one on every third rising clock edge, and the first increment lands on the third edge after reset is released.
- R2: A read accepted at an edge returns, after that edge, the count as it stood before that edge. Offset 0x8 gives count bits 31:0 and offset 0xC gives bits 63:32. `bus_rvalid` is high in the cycle after `bus_rd`.
- R3: Writes to offsets 0x8 and 0xC are ignored and do not change the count.
- R4: Target low word is at 0x10020. Target high word is at 0x10024, keeps only bits 19:0, and reads zero in bits 31:20.
- R5: The control word is at 0x1002C. Bit 0 is the enable, bit 1 is the interrupt gate (1 = interrupt allowed) and bit 2 is the hit flag. Writes to bit 2 are ignored, and bits 31:3 read zero.
- R6: While the enable is 1 and the count is greater than or equal to the zero-extended 52-bit target, the hit flag sets at the next edge. It then stays set as long as the enable stays 1, even when the interrupt gate changes.
- R7: A control write that clears the enable clears the hit flag at the same edge. The interrupt output is low from then on.
- R8: `irq` is high exactly when the enable, the hit flag and the interrupt gate are all 1.
- R9: Reset clears the count, the target, the control word and the hit flag, and holds `irq` and `bus_rvalid` low.
- R10: Reads of any offset not listed above return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 17 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq | output | 1 | Compare interrupt |

## Verification
The assertions assume a synchronous reset that is held for at least one edge. They also assume that `bus_wr` and `bus_rd` are never unknown once reset has been released, and that a control write is the only way the enable changes. The stimulus drives every bus signal at falling edges, with known values from time zero. It holds each strobe for exactly one rising edge and never issues a read and a write in the same cycle. The compare checks run right after a fresh reset, so the count is always known from the bench's own edge counter and stays far below 2^32. One test places the target in the high word, so the high bits are shown to take part in the comparison.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;
  localparam int unsigned ADDR_W      = 17;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned CNT_W       = 64;
  localparam int unsigned TGT_HI_W    = 20;
  localparam int unsigned TGT_W       = DATA_W + TGT_HI_W;
  localparam int unsigned PRESCALE    = 3;

  localparam int unsigned OFS_CNT_LO  = 'h00008;
  localparam int unsigned OFS_CNT_HI  = 'h0000C;
  localparam int unsigned OFS_TGT_LO  = 'h10020;
  localparam int unsigned OFS_TGT_HI  = 'h10024;
  localparam int unsigned OFS_CTRL    = 'h1002C;

  localparam int unsigned BIT_EN      = 0;
  localparam int unsigned BIT_GATE    = 1;
  localparam int unsigned BIT_HIT     = 2;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CNT_LO, SEL_CNT_HI, SEL_TGT_LO, SEL_TGT_HI, SEL_CTRL
  } reg_sel_e;
endpackage

// File: rtl/cmpt_prescale.sv
module cmpt_prescale #(
  parameter int unsigned DIV = 3
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned PH_W = $clog2(DIV);
      localparam logic [PH_W-1:0] LAST = PH_W'(DIV - 1);
      logic [PH_W-1:0] phase;
      always_ff @(posedge clk) begin
        if (rst)               phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                   phase <= phase + 1'b1;
      end
      assign tick = (phase == LAST);
    end
  endgenerate
endmodule

// File: rtl/cmpt_counter.sv
module cmpt_counter #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)       value <= '0;
    else if (tick) value <= value + 1'b1;
  end
endmodule

// File: rtl/cmpt_compare.sv
module cmpt_compare #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HI_W   = 20,
  parameter int unsigned EN_B   = 0,
  parameter int unsigned GATE_B = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [CNT_W-1:0]       count,
  input  logic                   wr_lo,
  input  logic                   wr_hi,
  input  logic                   wr_ctrl,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W+HI_W-1:0] target,
  output logic                   en,
  output logic                   gate,
  output logic                   hit
);
  localparam int unsigned TGT_W = DATA_W + HI_W;

  logic [DATA_W-1:0] tgt_lo;
  logic [HI_W-1:0]   tgt_hi;
  logic              en_next;
  logic              reached;

  assign target  = {tgt_hi, tgt_lo};
  assign reached = count >= CNT_W'(target);
  assign en_next = wr_ctrl ? wdata[EN_B] : en;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_lo <= '0;
      tgt_hi <= '0;
      en     <= 1'b0;
      gate   <= 1'b0;
      hit    <= 1'b0;
    end else begin
      if (wr_lo) tgt_lo <= wdata;
      if (wr_hi) tgt_hi <= wdata[HI_W-1:0];
      if (wr_ctrl) gate <= wdata[GATE_B];
      en  <= en_next;
      hit <= en_next & (hit | (en & reached));
    end
  end

  logic unused_ok;
  assign unused_ok = ^TGT_W;
endmodule

// File: rtl/cmpt_timer.sv
module cmpt_timer
  import cmpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              irq
);
  logic              tick;
  logic [CNT_W-1:0]  cnt_val;
  logic [TGT_W-1:0]  tgt_val;
  logic              ctl_en, ctl_gate, ctl_hit;
  reg_sel_e          sel;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    unique case (bus_addr)
      ADDR_W'(OFS_CNT_LO): sel = SEL_CNT_LO;
      ADDR_W'(OFS_CNT_HI): sel = SEL_CNT_HI;
      ADDR_W'(OFS_TGT_LO): sel = SEL_TGT_LO;
      ADDR_W'(OFS_TGT_HI): sel = SEL_TGT_HI;
      ADDR_W'(OFS_CTRL):   sel = SEL_CTRL;
      default:             sel = SEL_NONE;
    endcase
  end

  cmpt_prescale #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .tick(tick)
  );

  cmpt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .value(cnt_val)
  );

  cmpt_compare #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .HI_W(TGT_HI_W),
    .EN_B(BIT_EN), .GATE_B(BIT_GATE)
  ) u_cmp (
    .clk(clk), .rst(rst), .count(cnt_val),
    .wr_lo(bus_wr && sel == SEL_TGT_LO),
    .wr_hi(bus_wr && sel == SEL_TGT_HI),
    .wr_ctrl(bus_wr && sel == SEL_CTRL),
    .wdata(bus_wdata), .target(tgt_val),
    .en(ctl_en), .gate(ctl_gate), .hit(ctl_hit)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CNT_LO: rd_mux = cnt_val[DATA_W-1:0];
      SEL_CNT_HI: rd_mux = cnt_val[2*DATA_W-1:DATA_W];
      SEL_TGT_LO: rd_mux = tgt_val[DATA_W-1:0];
      SEL_TGT_HI: rd_mux = DATA_W'(tgt_val[TGT_W-1:DATA_W]);
      SEL_CTRL: begin
        rd_mux[BIT_EN]   = ctl_en;
        rd_mux[BIT_GATE] = ctl_gate;
        rd_mux[BIT_HIT]  = ctl_hit;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  assign irq = ctl_en & ctl_hit & ctl_gate;
endmodule

// File: rtl/cmpt_timer_chk.sv
module cmpt_timer_chk #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned TGT_W = 52
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt,
  input logic [TGT_W-1:0] tgt,
  input logic             en,
  input logic             gate,
  input logic             hit,
  input logic             irq,
  input logic             rd,
  input logic             rvalid
);
  a_r1_step_by_one: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt) |-> cnt == $past(cnt) + 1'b1);
  a_r1_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt) |=> $stable(cnt));
  a_r2_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
    rd |=> rvalid);
  a_r6_sets_on_reach: assert property (@(posedge clk) disable iff (rst)
    (en && cnt >= CNT_W'(tgt)) |=> (hit || !en));
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (hit && en) |=> (hit || !en));
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
    !en |-> (!hit && !irq));
  a_r8_needs_gate: assert property (@(posedge clk) disable iff (rst)
    !gate |-> !irq);
  a_r8_needs_hit: assert property (@(posedge clk) disable iff (rst)
    irq |-> hit);
endmodule

bind cmpt_timer cmpt_timer_chk #(.CNT_W(cmpt_pkg::CNT_W), .TGT_W(cmpt_pkg::TGT_W)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt_val), .tgt(tgt_val), .en(ctl_en),
  .gate(ctl_gate), .hit(ctl_hit), .irq(irq), .rd(bus_rd), .rvalid(bus_rvalid)
);

// File: tb/tb_cmpt_timer.sv
module tb_cmpt_timer;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [16:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int edges  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) edges <= rst ? 0 : edges + 1;

  cmpt_timer dut (.*);

  // {write, addr, data, expected read}
  localparam logic [81:0] VEC [NV] = '{
    {1'b0, 17'h10020, 32'h0,        32'h0},
    {1'b0, 17'h1002C, 32'h0,        32'h0},
    {1'b1, 17'h10020, 32'hDEADBEEF, 32'h0},
    {1'b0, 17'h10020, 32'h0,        32'hDEADBEEF},
    {1'b1, 17'h10024, 32'hFFFFFFFF, 32'h0},
    {1'b0, 17'h10024, 32'h0,        32'h000FFFFF},
    {1'b1, 17'h1002C, 32'hFFFFFFF6, 32'h0},
    {1'b0, 17'h1002C, 32'h0,        32'h00000002},
    {1'b1, 17'h1002C, 32'h0,        32'h0},
    {1'b1, 17'h0000C, 32'hFFFFFFFF, 32'h0},
    {1'b0, 17'h0000C, 32'h0,        32'h0},
    {1'b0, 17'h00004, 32'h0,        32'h0},
    {1'b0, 17'h10028, 32'h0,        32'h0},
    {1'b0, 17'h01000, 32'h0,        32'h0},
    {1'b1, 17'h10024, 32'h0,        32'h0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [16:0] a, output logic [31:0] d, output logic v);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    logic        v;
    do_reset();
    // R9 reset state
    check("R9 irq", irq, 0);
    check("R9 rvalid", bus_rvalid, 0);

    // R1, R2: count low half, first step on third edge
    for (int i = 0; i < 10; i++) begin
      rd(17'h00008, d, v);
      check("R1 count low", d, (edges - 1) / 3);
      check("R2 rvalid", v, 1);
    end

    // R3: write to count low is ignored
    wr(17'h00008, 32'hFFFFFFFF);
    rd(17'h00008, d, v);
    check("R3 count write ignored", d, (edges - 1) / 3);

    // R4, R5, R10, R9: register table
    do_reset();
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][81]) begin
        wr(VEC[i][80:64], VEC[i][63:32]);
      end else begin
        rd(VEC[i][80:64], d, v);
        check("R4/R5/R9/R10 table", d, VEC[i][31:0]);
      end
    end

    // R6: equality sets the flag one edge after count reaches target
    do_reset();
    wr(17'h10020, 32'd10);
    wr(17'h10024, 32'd0);
    wr(17'h1002C, 32'd3);
    while (edges < 30) @(negedge clk);
    check("R6 no irq before reach", irq, 0);
    @(negedge clk);
    check("R6 irq at reach", irq, 1);

    // R8: gate off masks the interrupt, flag stays
    wr(17'h1002C, 32'd1);
    check("R8 gate off", irq, 0);
    rd(17'h1002C, d, v);
    check("R6 flag sticky", d, 32'd5);
    wr(17'h1002C, 32'd3);
    check("R8 gate back on", irq, 1);

    // R7: clearing enable acknowledges
    wr(17'h1002C, 32'd2);
    check("R7 irq cleared", irq, 0);
    rd(17'h1002C, d, v);
    check("R7 flag cleared", d, 32'd2);
    wr(17'h1002C, 32'd3);
    @(negedge clk);
    rd(17'h1002C, d, v);
    check("R6 sets again past target", d, 32'd7);
    check("R8 irq again", irq, 1);

    // R4/R6: high word of target takes part
    wr(17'h1002C, 32'd0);
    wr(17'h10024, 32'd1);
    wr(17'h10020, 32'd0);
    wr(17'h1002C, 32'd3);
    repeat (20) @(negedge clk);
    rd(17'h1002C, d, v);
    check("R6 high target not reached", d, 32'd3);
    check("R8 no irq far target", irq, 0);

    done = 1'b1;
    finish_run();
  end
endmodule